// File: doc/BRIEF.md
# Banked Activation Tensor Store

This block holds the feature-map tensors that a compute array consumes and produces. It serves five requestors in the same clock cycle: three readers (two operand streams for the array and one spill reader that drains a finished output tensor) and two writers (the array's result stream and a restore writer that brings in the next input tensor). Two operand readers are enough for element-wise addition, which reads two input tensors and writes one output tensor.

Storage is made of three physical banks. Each bank has one read port and one write port. A steering stage decodes the upper address bits of every valid request to find its bank. It then routes the request to that bank's single read or write port. The design assumes that tensor placement keeps concurrent accesses on separate banks. When two requests of the same kind meet on one bank, nothing is queued: the lowest-numbered requestor is served, the others are dropped, and a sticky error flag is raised. Each word is 64 bits and carries eight 8-bit activations, with byte k at bits 8k+7:8k. Placing two instances side by side gives sixteen values per read.

Top module: `tensor_act_mem`

## Requirements
- R1: Three valid reads that target three different banks in one cycle are all served. Each returns the word stored at its address.
- R2: Two valid writes that target different banks in one cycle are both stored.
- R3: An address is {bank, word}. The bank field is the top 2 bits and the word field is the low 6 bits. Bank values 0 to 2 select a bank. A request with bank field 3 is ignored: it returns no data and writes nothing. It also sets the error flag.
- R4: Read data appears on the return lane of the requestor that issued it, with that lane's valid high. This happens in the cycle that follows the request cycle. A lane's return valid is low in any cycle that does not follow a served read from that lane.
- R5: When two or more reads target the same bank in one cycle, only the lowest-numbered reader receives data. The error flag is set.
- R6: When both writes target the same bank in one cycle, only writer 0 is stored and writer 1's data is discarded. The error flag is set.
- R7: The error flag stays set until reset. Reset clears the error flag and all return valids.
- R8: A read and a write to the same word in the same cycle return the word's previous contents. The new value is seen by later reads.
- R9: A read and a write to the same bank in the same cycle both proceed and do not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_vld | input | 3 | Read request valid, one bit per reader (0, 1 operand; 2 spill) |
| rd_req_addr | input | 24 | Read addresses, 8 bits per reader, reader r at bits 8r+7:8r |
| wr_req_vld | input | 2 | Write request valid (0 array result, 1 restore) |
| wr_req_addr | input | 16 | Write addresses, 8 bits per writer |
| wr_req_data | input | 128 | Write data, 64 bits per writer |
| rd_rsp_vld | output | 3 | Return valid per read lane |
| rd_rsp_data | output | 192 | Return data, 64 bits per read lane |
| clash_err | output | 1 | Sticky collision or bad-bank error |

## Verification
If the per-bank register that records which reader won the bank holds a wrong value, the returned data lands on the wrong lane, or on none. This is visible one cycle after the request. A bad bank decode or a bad write-data select causes a wrong word to be stored. That error only shows at a later read of that word, so the tests read back every address they have written. A loss of the sticky error state shows in the idle cycles that follow a collision.

// File: rtl/act_mem_pkg.sv
package act_mem_pkg;
    localparam int NUM_BANKS = 3;
    localparam int NUM_RD    = 3;
    localparam int NUM_WR    = 2;
    localparam int LANE_BITS = 8;
    localparam int BANK_AW   = $clog2(NUM_BANKS + 1);

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    localparam int RD_IDX_W = idx_width(NUM_RD);
    localparam int WR_IDX_W = idx_width(NUM_WR);
endpackage

// File: rtl/sdp_bank.sv
module sdp_bank #(
    parameter int DEPTH = 64,
    parameter int W     = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // read sees contents before a same-cycle write
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem_q[raddr];
        end
    end
endmodule

// File: rtl/bank_steer.sv
module bank_steer #(
    parameter int N_REQ   = 3,
    parameter int N_BANK  = 3,
    parameter int BANK_AW = 2,
    parameter int WORD_AW = 6,
    localparam int ADDR_W = BANK_AW + WORD_AW,
    localparam int IDX_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0]         req_vld,
    input  logic [N_REQ*ADDR_W-1:0]  req_addr,
    output logic [N_BANK-1:0]        gnt_vld,
    output logic [N_BANK*IDX_W-1:0]  gnt_idx,
    output logic [N_BANK*WORD_AW-1:0] gnt_word,
    output logic                     clash
);
    logic [BANK_AW-1:0] bk;
    logic [WORD_AW-1:0] wd;

    // lowest index claims a bank first; later hits on a claimed bank are collisions
    always_comb begin
        gnt_vld  = '0;
        gnt_idx  = '0;
        gnt_word = '0;
        clash    = 1'b0;
        bk       = '0;
        wd       = '0;
        for (int i = 0; i < N_REQ; i++) begin
            bk = req_addr[i*ADDR_W+WORD_AW +: BANK_AW];
            wd = req_addr[i*ADDR_W +: WORD_AW];
            if (req_vld[i]) begin
                if (int'(bk) >= N_BANK) begin
                    clash = 1'b1;
                end else if (gnt_vld[bk]) begin
                    clash = 1'b1;
                end else begin
                    gnt_vld[bk]                      = 1'b1;
                    gnt_idx[int'(bk)*IDX_W +: IDX_W]   = IDX_W'(i);
                    gnt_word[int'(bk)*WORD_AW +: WORD_AW] = wd;
                end
            end
        end
    end
endmodule

// File: rtl/tensor_act_mem.sv
module tensor_act_mem
    import act_mem_pkg::*;
#(
    parameter int BANK_WORDS = 64,
    parameter int LANES      = 8,
    localparam int WORD_W    = LANES * LANE_BITS,
    localparam int WORD_AW   = $clog2(BANK_WORDS),
    localparam int ADDR_W    = BANK_AW + WORD_AW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_RD-1:0]        rd_req_vld,
    input  logic [NUM_RD*ADDR_W-1:0] rd_req_addr,
    input  logic [NUM_WR-1:0]        wr_req_vld,
    input  logic [NUM_WR*ADDR_W-1:0] wr_req_addr,
    input  logic [NUM_WR*WORD_W-1:0] wr_req_data,
    output logic [NUM_RD-1:0]        rd_rsp_vld,
    output logic [NUM_RD*WORD_W-1:0] rd_rsp_data,
    output logic                     clash_err
);
    typedef struct packed {
        logic [NUM_BANKS-1:0]          act;
        logic [NUM_BANKS*RD_IDX_W-1:0] tag;
        logic                          err;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_BANKS-1:0]          rg_vld, wg_vld;
    logic [NUM_BANKS*RD_IDX_W-1:0] rg_idx;
    logic [NUM_BANKS*WR_IDX_W-1:0] wg_idx;
    logic [NUM_BANKS*WORD_AW-1:0]  rg_word, wg_word;
    logic                          rd_clash, wr_clash;
    logic [WORD_W-1:0]             bank_wdata [NUM_BANKS];
    logic [WORD_W-1:0]             bank_rdata [NUM_BANKS];

    bank_steer #(.N_REQ(NUM_RD), .N_BANK(NUM_BANKS), .BANK_AW(BANK_AW), .WORD_AW(WORD_AW)) rd_steer_i (
        .req_vld (rd_req_vld),
        .req_addr(rd_req_addr),
        .gnt_vld (rg_vld),
        .gnt_idx (rg_idx),
        .gnt_word(rg_word),
        .clash   (rd_clash)
    );

    bank_steer #(.N_REQ(NUM_WR), .N_BANK(NUM_BANKS), .BANK_AW(BANK_AW), .WORD_AW(WORD_AW)) wr_steer_i (
        .req_vld (wr_req_vld),
        .req_addr(wr_req_addr),
        .gnt_vld (wg_vld),
        .gnt_idx (wg_idx),
        .gnt_word(wg_word),
        .clash   (wr_clash)
    );

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_wdata[b] = wr_req_data[int'(wg_idx[b*WR_IDX_W +: WR_IDX_W])*WORD_W +: WORD_W];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdp_bank #(.DEPTH(BANK_WORDS), .W(WORD_W)) bank_i (
            .clk  (clk),
            .we   (wg_vld[b]),
            .waddr(wg_word[b*WORD_AW +: WORD_AW]),
            .wdata(bank_wdata[b]),
            .re   (rg_vld[b]),
            .raddr(rg_word[b*WORD_AW +: WORD_AW]),
            .rdata(bank_rdata[b])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.act = rg_vld;
        st_d.tag = rg_idx;
        st_d.err = st_q.err | rd_clash | wr_clash;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // each bank's registered data goes back on the lane that owned it
    always_comb begin
        rd_rsp_vld  = '0;
        rd_rsp_data = '0;
        for (int r = 0; r < NUM_RD; r++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (st_q.act[b] && (st_q.tag[b*RD_IDX_W +: RD_IDX_W] == RD_IDX_W'(r))) begin
                    rd_rsp_vld[r]                 = 1'b1;
                    rd_rsp_data[r*WORD_W +: WORD_W] = bank_rdata[b];
                end
            end
        end
    end

    assign clash_err = st_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        clash_err |=> clash_err); // R7

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd_chk
        AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            rd_rsp_vld[r] |-> $past(rd_req_vld[r])); // R4
        AST_BAD_BANK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req_vld[r] && int'(rd_req_addr[r*ADDR_W+WORD_AW +: BANK_AW]) >= NUM_BANKS)
            |=> (clash_err && !rd_rsp_vld[r])); // R3
        for (genvar j = r + 1; j < NUM_RD; j++) begin : g_pair
            AST_RD_LOSER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_req_vld[r] && rd_req_vld[j] &&
                 rd_req_addr[r*ADDR_W+WORD_AW +: BANK_AW] == rd_req_addr[j*ADDR_W+WORD_AW +: BANK_AW])
                |=> (!rd_rsp_vld[j] && clash_err)); // R5
        end
    end

    AST_WR_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_vld[0] && wr_req_vld[1] &&
         wr_req_addr[WORD_AW +: BANK_AW] == wr_req_addr[ADDR_W+WORD_AW +: BANK_AW])
        |=> clash_err); // R6
endmodule

// File: tb/tensor_act_mem_tb_top.sv
module tensor_act_mem_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   rd_req_vld = '0;
    logic [23:0]  rd_req_addr = '0;
    logic [1:0]   wr_req_vld = '0;
    logic [15:0]  wr_req_addr = '0;
    logic [127:0] wr_req_data = '0;
    logic [2:0]   rd_rsp_vld;
    logic [191:0] rd_rsp_data;
    logic         clash_err;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [63:0] VA = 64'h0102_0304_0506_0708;
    localparam logic [63:0] VB = 64'h1111_2222_3333_4444;
    localparam logic [63:0] VC = 64'hA5A5_5A5A_C3C3_3C3C;
    localparam logic [63:0] VD = 64'hDEAD_BEEF_0BAD_F00D;
    localparam logic [63:0] VE = 64'h0F0E_0D0C_0B0A_0908;
    localparam logic [63:0] VF = 64'h7777_8888_9999_AAAA;
    localparam logic [63:0] VG = 64'h1234_5678_9ABC_DEF0;

    always #10 clk = ~clk;

    tensor_act_mem dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_req_vld(rd_req_vld), .rd_req_addr(rd_req_addr),
        .wr_req_vld(wr_req_vld), .wr_req_addr(wr_req_addr), .wr_req_data(wr_req_data),
        .rd_rsp_vld(rd_rsp_vld), .rd_rsp_data(rd_rsp_data), .clash_err(clash_err)
    );

    function automatic logic [7:0] mk(input int bank, input int word);
        return {bank[1:0], word[5:0]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lane(input int r);
        return rd_rsp_data[r*64 +: 64];
    endfunction

    // called at a falling edge; returns at the next falling edge with responses visible
    task automatic issue(input logic [2:0] rv, input logic [7:0] ra0, input logic [7:0] ra1,
                         input logic [7:0] ra2, input logic [1:0] wv, input logic [7:0] wa0,
                         input logic [7:0] wa1, input logic [63:0] wd0, input logic [63:0] wd1);
        rd_req_vld  = rv;
        rd_req_addr = {ra2, ra1, ra0};
        wr_req_vld  = wv;
        wr_req_addr = {wa1, wa0};
        wr_req_data = {wd1, wd0};
        @(negedge clk);
        rd_req_vld = '0;
        wr_req_vld = '0;
    endtask

    task automatic idle();
        issue(3'b000, 8'h0, 8'h0, 8'h0, 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R7 reset valids", 64'(rd_rsp_vld), 64'h0);
        chk("R7 reset error", 64'(clash_err), 64'h0);
    endtask

    task automatic t_parallel_write();
        issue(3'b000, 8'h0, 8'h0, 8'h0, 2'b11, mk(0, 5), mk(1, 9), VA, VB);
        chk("R2 no error on split writes", 64'(clash_err), 64'h0);
        issue(3'b000, 8'h0, 8'h0, 8'h0, 2'b11, mk(2, 3), mk(0, 33), VC, VF);
        issue(3'b000, 8'h0, 8'h0, 8'h0, 2'b10, 8'h0, mk(2, 7), 64'h0, VG);
        issue(3'b001, mk(0, 33), 8'h0, 8'h0, 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
        chk("R2 restore writer stored", lane(0), VF);
    endtask

    task automatic t_parallel_read();
        issue(3'b111, mk(2, 3), mk(0, 5), mk(1, 9), 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
        chk("R4 all lanes valid", 64'(rd_rsp_vld), 64'h7);
        chk("R1 lane0 data", lane(0), VC);
        chk("R1 lane1 data", lane(1), VA);
        chk("R1 lane2 data", lane(2), VB);
        chk("R1 no error", 64'(clash_err), 64'h0);
        idle();
        chk("R4 valids drop when idle", 64'(rd_rsp_vld), 64'h0);
    endtask

    task automatic t_same_word();
        issue(3'b001, mk(0, 5), 8'h0, 8'h0, 2'b01, mk(0, 5), 8'h0, VD, 64'h0);
        chk("R8 old data returned", lane(0), VA);
        chk("R9 read+write same bank no error", 64'(clash_err), 64'h0);
        issue(3'b010, 8'h0, mk(0, 5), 8'h0, 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
        chk("R8 new data later", lane(1), VD);
        chk("R4 only lane1 valid", 64'(rd_rsp_vld), 64'h2);
    endtask

    task automatic t_rd_clash();
        issue(3'b101, mk(1, 9), 8'h0, mk(1, 0), 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
        chk("R5 only lane0 served", 64'(rd_rsp_vld), 64'h1);
        chk("R5 winner data", lane(0), VB);
        chk("R5 error set", 64'(clash_err), 64'h1);
        do_reset();
        issue(3'b110, 8'h0, mk(2, 3), mk(2, 7), 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
        chk("R5 lane1 beats lane2", 64'(rd_rsp_vld), 64'h2);
        chk("R5 lane1 data", lane(1), VC);
        chk("R5 error set again", 64'(clash_err), 64'h1);
        do_reset();
    endtask

    task automatic t_wr_clash();
        issue(3'b000, 8'h0, 8'h0, 8'h0, 2'b11, mk(2, 3), mk(2, 7), VE, VF);
        chk("R6 error set", 64'(clash_err), 64'h1);
        issue(3'b001, mk(2, 3), 8'h0, 8'h0, 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
        chk("R6 writer0 stored", lane(0), VE);
        issue(3'b001, mk(2, 7), 8'h0, 8'h0, 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
        chk("R6 writer1 discarded", lane(0), VG);
    endtask

    task automatic t_sticky();
        repeat (5) idle();
        chk("R7 error held", 64'(clash_err), 64'h1);
        do_reset();
        chk("R7 error cleared by reset", 64'(clash_err), 64'h0);
    endtask

    task automatic t_bad_bank();
        issue(3'b010, 8'h0, 8'hC5, 8'h0, 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
        chk("R3 bad bank read no return", 64'(rd_rsp_vld), 64'h0);
        chk("R3 bad bank sets error", 64'(clash_err), 64'h1);
        do_reset();
        issue(3'b000, 8'h0, 8'h0, 8'h0, 2'b01, 8'hC5, 8'h0, VF, 64'h0);
        chk("R3 bad bank write sets error", 64'(clash_err), 64'h1);
        issue(3'b001, mk(0, 5), 8'h0, 8'h0, 2'b00, 8'h0, 8'h0, 64'h0, 64'h0);
        chk("R3 bank0 word unchanged", lane(0), VD);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_parallel_write();
        t_parallel_read();
        t_same_word();
        t_rd_clash();
        t_wr_clash();
        t_sticky();
        t_bad_bank();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule